// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller pulses `start_i` together with the 9-bit start column, a burst-length code and a burst-type bit. From the next cycle the block drives one column per clock on `col_o`, with `beat_valid_o` high. When a finite burst completes, it raises a one-cycle `done_o` in the cycle after the last beat.

The beat order depends on the burst type. In sequential order the low bits count upward and wrap inside a block aligned to the burst length. In interleave order the low bits are the start bits XOR the beat index. A full-page burst walks through all 512 columns of the page and wraps. It runs until a stop request or a new start ends it. A new start may replace a running burst on any clock. Illegal length settings fall back to a single beat and are flagged.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is applied and after it is released, with no start issued, `beat_valid_o`, `done_o` and `cfg_err_o` are 0.
- R2: In the cycle after `start_i` is sampled high, `beat_valid_o` is 1 and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: Sequential type (`btype_i`=0) with length code 1, 2 or 3 (N = 2, 4, 8): beat k carries upper bits equal to the start and low log2(N) bits equal to (start + k) mod N. Start 5 with N=8 gives 5,6,7,0,1,2,3,4.
- R4: Interleave type (`btype_i`=1) with length N: beat k carries low log2(N) bits equal to the start bits XOR k, and upper bits unchanged. Start 5 with N=8 gives 5,4,7,6,1,0,3,2.
- R5: Length code 0 gives exactly one beat, at the start column.
- R6: Length code 7 with sequential type is a full-page burst. The column rises by one each cycle modulo 512 and continues until stopped or restarted.
- R7: `done_o` is a one-cycle pulse in the cycle after the last beat of a finite burst, with `beat_valid_o` low in that cycle. It is never raised during or after a full-page burst.
- R8: `stop_i` sampled high during a burst, with no `start_i`, drops `beat_valid_o` from the next cycle and suppresses `done_o`.
- R9: `start_i` sampled during a running burst abandons it without a `done_o` and begins the new burst at its own column in the next cycle.
- R10: Length codes 4, 5 and 6, and code 7 with interleave type, run as a single beat at the start column. In that beat `cfg_err_o` is 1, and `done_o` follows in the next cycle.
- R11: `blen_i`, `btype_i` and `start_col_i` are sampled only with `start_i`. Changing them during a burst has no effect on its columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (also interrupts a running one) |
| start_col_i | input | 9 | Start column of the burst |
| blen_i | input | 3 | Length code: 0..3 = 1,2,4,8 beats, 7 = full page, others reserved |
| btype_i | input | 1 | 0 = sequential, 1 = interleave |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column of the current beat |
| beat_valid_o | output | 1 | A beat is present on `col_o` |
| done_o | output | 1 | One-cycle pulse after the last beat of a finite burst |
| cfg_err_o | output | 1 | Beat was produced from an illegal length/type setting |

## Verification
Some properties are checked on every cycle. Beat 0 must carry the sampled start column. A stop or restart must never be followed by `done_o`. `done_o` must come only right after a beat. Upper column bits must stay fixed within a finite burst. A full page must advance by exactly one per beat. The exact wrap orders cannot be shown by those properties, nor can the length of each burst. The bench's directed scenarios cover these. They also cover that mid-burst changes of the configuration inputs are ignored, and the single-beat fallback for each illegal setting.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic {
    BT_SEQ = 1'b0,
    BT_ILV = 1'b1
  } btype_e;
endpackage

// File: rtl/colgen_cfg_decode.sv
module colgen_cfg_decode #(
  parameter int COL_W   = 9,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  colgen_pkg::btype_e btype_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              page_o,
  output logic              err_o
);
  localparam logic [CODE_W-1:0] PageCode = '1;
  localparam logic [CODE_W-1:0] MaxCode  = CODE_W'(MAX_LOG);

  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    err_o  = 1'b0;
    if (code_i == PageCode) begin
      if (btype_i == colgen_pkg::BT_ILV) begin
        err_o = 1'b1;
      end else begin
        page_o = 1'b1;
        mask_o = '1;
      end
    end else if (code_i <= MaxCode) begin
      mask_o = COL_W'((32'd1 << code_i) - 32'd1);
    end else begin
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             active_o,
  output logic             done_o
);
  logic [COL_W-1:0] beat_q, mask_q;
  logic             page_q, active_q, done_q;
  logic             last_w;

  // a full page never reaches a last beat
  assign last_w = !page_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q   <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        beat_q   <= '0;
        mask_q   <= mask_i;
        page_q   <= page_i;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (stop_i) begin
          active_q <= 1'b0;
        end else if (last_w) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign page_o   = page_q;
  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  colgen_pkg::btype_e btype_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low_w;

  always_comb begin
    if (btype_i == colgen_pkg::BT_ILV) low_w = base_i ^ beat_i;
    else                               low_w = base_i + beat_i;
    col_o = (base_i & ~mask_i) | (low_w & mask_i);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W   = 9,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] blen_i,
  input  logic              btype_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  import colgen_pkg::*;

  btype_e           btype_w, btype_q;
  logic [COL_W-1:0] dec_mask_w, mask_w, beat_w, base_q;
  logic             dec_page_w, dec_err_w, page_w, err_q;

  assign btype_w = btype_e'(btype_i);

  colgen_cfg_decode #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_dec (
    .code_i (blen_i),
    .btype_i(btype_w),
    .mask_o (dec_mask_w),
    .page_o (dec_page_w),
    .err_o  (dec_err_w)
  );

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .mask_i  (dec_mask_w),
    .page_i  (dec_page_w),
    .beat_o  (beat_w),
    .mask_o  (mask_w),
    .page_o  (page_w),
    .active_o(beat_valid_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      btype_q <= BT_SEQ;
      err_q   <= 1'b0;
    end else begin
      // illegal settings are single-beat, so the flag only lives in beat 0
      err_q <= start_i & dec_err_w;
      if (start_i) begin
        base_q  <= start_col_i;
        btype_q <= btype_w;
      end
    end
  end

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (base_q),
    .beat_i (beat_w),
    .mask_i (mask_w),
    .btype_i(btype_q),
    .col_o  (col_o)
  );

  assign cfg_err_o = err_q;
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W   = 9,
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic [CODE_W-1:0] blen_i,
  input logic              btype_i,
  input logic              stop_i,
  input logic [COL_W-1:0]  col_o,
  input logic              beat_valid_o,
  input logic              done_o,
  input logic              cfg_err_o,
  input logic              page_i
);
  localparam logic [CODE_W-1:0] PageCode = '1;

  a_r2_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> beat_valid_o && (col_o == $past(start_col_i)));

  a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !beat_valid_o && !done_o);

  a_r9_restart_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  a_r7_done_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !beat_valid_o && $past(beat_valid_o));

  a_r3_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !page_i && $past(beat_valid_o) && !$past(start_i))
      |-> col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG]));

  a_r6_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && page_i && $past(beat_valid_o) && !$past(start_i))
      |-> col_o == COL_W'($past(col_o) + 1'b1));

  a_r10_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && btype_i && blen_i == PageCode) |=> cfg_err_o && beat_valid_o);

  a_r1_err_only_in_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> beat_valid_o);
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .blen_i      (blen_i),
  .btype_i     (btype_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .beat_valid_o(beat_valid_o),
  .done_o      (done_o),
  .cfg_err_o   (cfg_err_o),
  .page_i      (page_w)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] scol = '0;
  logic [2:0] blen = '0;
  logic       btype = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] col;
  logic       vld, done, err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdram_burst_colgen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .blen_i(blen), .btype_i(btype), .stop_i(stop),
    .col_o(col), .beat_valid_o(vld), .done_o(done), .cfg_err_o(err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int k, int n, bit ilv);
    int base = s - (s % n);
    if (ilv) return base + ((s % n) ^ k);
    return base + (((s % n) + k) % n);
  endfunction

  task automatic issue(int s, int code, bit bt);
    @(negedge clk);
    start = 1'b1; scol = 9'(s); blen = 3'(code); btype = bt;
    @(negedge clk);
    start = 1'b0;
  endtask

  // expects an issued burst; checks n beats then done pulse
  task automatic expect_beats(string req, int s, int n, bit ilv, bit eflag);
    for (int k = 0; k < n; k++) begin
      chk(req, "valid", vld, 1);
      chk(req, "col", col, exp_col(s, k, n, ilv));
      chk(req, "done early", done, 0);
      if (k == 0) chk(req, "cfg_err", err, eflag);
      @(negedge clk);
    end
    chk(req, "valid after last", vld, 0);
    chk(req, "done pulse", done, 1);
    @(negedge clk);
    chk(req, "done width", done, 0);
  endtask

  task automatic t_reset;
    chk("R1", "valid in reset", vld, 0);
    chk("R1", "done in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "valid idle", vld, 0);
    chk("R1", "done idle", done, 0);
    chk("R1", "err idle", err, 0);
  endtask

  task automatic t_seq;
    issue(5, 3, 0);   expect_beats("R3", 5, 8, 0, 0);
    issue(9'h1AB, 2, 0); expect_beats("R3", 9'h1AB, 4, 0, 0);
    issue(9'h0F3, 1, 0); expect_beats("R2", 9'h0F3, 2, 0, 0);
  endtask

  task automatic t_ilv;
    issue(5, 3, 1);   expect_beats("R4", 5, 8, 1, 0);
    issue(9'h16E, 2, 1); expect_beats("R4", 9'h16E, 4, 1, 0);
    issue(9'h081, 1, 1); expect_beats("R4", 9'h081, 2, 1, 0);
  endtask

  task automatic t_len1;
    issue(9'h133, 0, 0); expect_beats("R5", 9'h133, 1, 0, 0);
    issue(9'h077, 0, 1); expect_beats("R5", 9'h077, 1, 1, 0);
  endtask

  task automatic t_page;
    issue(300, 7, 0);
    for (int k = 0; k < 530; k++) begin
      chk("R6", "valid", vld, 1);
      chk("R6", "col", col, (300 + k) % 512);
      chk("R7", "no done in page", done, 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R8", "valid after page stop", vld, 0);
    chk("R7", "no done after page", done, 0);
    @(negedge clk);
    chk("R7", "no late done", done, 0);
  endtask

  task automatic t_stop;
    issue(2, 3, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R8", "col", col, exp_col(2, k, 8, 0));
      @(negedge clk);
    end
    chk("R8", "col before stop", col, exp_col(2, 3, 8, 0));
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R8", "valid after stop", vld, 0);
    chk("R8", "done after stop", done, 0);
    repeat (8) begin
      @(negedge clk);
      chk("R8", "quiet after stop", vld | done, 0);
    end
  endtask

  task automatic t_interrupt;
    issue(1, 2, 1);
    chk("R9", "old beat0", col, exp_col(1, 0, 4, 1));
    @(negedge clk);
    chk("R9", "old beat1", col, exp_col(1, 1, 4, 1));
    start = 1'b1; scol = 9'h1F3; blen = 3'd3; btype = 1'b0;
    @(negedge clk); start = 1'b0;
    expect_beats("R9", 9'h1F3, 8, 0, 0);
    // restart on the last beat of a burst must also drop its done
    issue(4, 1, 0);
    chk("R9", "beat0", col, 4);
    @(negedge clk);
    chk("R9", "last beat", col, 5);
    start = 1'b1; scol = 9'h040; blen = 3'd0;
    @(negedge clk); start = 1'b0;
    chk("R9", "no done on restart", done, 0);
    expect_beats("R9", 9'h040, 1, 0, 0);
  endtask

  task automatic t_err;
    issue(9'h155, 5, 0); expect_beats("R10", 9'h155, 1, 0, 1);
    issue(9'h0AA, 4, 1); expect_beats("R10", 9'h0AA, 1, 1, 1);
    issue(9'h0C6, 6, 0); expect_beats("R10", 9'h0C6, 1, 0, 1);
    issue(9'h1E7, 7, 1); expect_beats("R10", 9'h1E7, 1, 1, 1);
  endtask

  task automatic t_ignore;
    issue(6, 2, 0);
    blen = 3'd0; btype = 1'b1; scol = 9'h1FF;
    expect_beats("R11", 6, 4, 0, 0);
    issue(3, 1, 1);
    blen = 3'd7; btype = 1'b0; scol = 9'h000;
    expect_beats("R11", 3, 2, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_len1();
    t_page();
    t_stop();
    t_interrupt();
    t_err();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule